// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block collects the event strobes of a USB on-the-go controller into two pending words and drives one level interrupt towards a processor. The first word holds endpoint events. Transmit endpoints occupy the low half. Receive endpoints occupy the high half, and there is no receive endpoint 0. The second word holds nine core events. Software reaches each word through seven registers on a 32-bit register bus:

- a raw pending view,
- write-one-to-set and write-one-to-clear ports,
- a directly writable enable mask,
- write-one mask-set and mask-clear ports,
- a masked pending view.

A few global registers complete the map. There is a constant revision word, a control word whose bit 0 resets all pending and enable state, a status word carrying a synchronized copy of the VBUS-drive level, and an end-of-interrupt port.

The interrupt line is deliberately one-shot. Once it has been raised, it cannot be raised again until software writes the end-of-interrupt port, even after it has dropped. This lets a handler clear what it saw, acknowledge, and rely on a fresh edge if anything is still pending or has arrived since. Software can also inject any event through the set ports. This is used, for example, to force the VBUS-drive-change core event (core word bit 24) so that polling starts.

Top module: `usb_irq_agg`

## Requirements
- R1: Reads return the following. Offset 0x00 returns the constant parameter REV_ID, which is nonzero. Offset 0x04 returns 0. Offset 0x08 returns, in bit 0, the vbusDrvIn level delayed by a two-flop synchronizer, so a change shows after the second rising edge. Reads of unmapped offsets return 0.
- R2: A one-cycle pulse on epTxEvt[i] sets bit i of the endpoint pending word (read at 0x20). A pulse on epRxEvt[j] (j = 1..15) sets bit 16+j. Bit 16 is never set, even through the set port, and always reads 0.
- R3: A pulse on coreEvt[k] (k = 0..8) sets bit 16+k of the core pending word (read at 0x40). All other core bits read 0. Writing 1 to bit 24 at the core set port (0x44) forces the VBUS-drive-change event pending.
- R4: The set ports (0x24, 0x44) and clear ports (0x28, 0x48) act only on the bits written as 1; zero bits leave pending bits unchanged. All four write-only ports (set, clear, mask-set, mask-clear) read 0. Writes to the raw pending offsets (0x20, 0x40) have no effect.
- R5: The mask registers (0x2C, 0x4C) are written directly and read back, with unimplemented bits reading 0. Mask-set (0x30, 0x50) ORs in the 1 bits and mask-clear (0x34, 0x54) removes them. The masked view (0x38, 0x58) reads pending AND mask.
- R6: While armed, a masked pending bit that is visible after a rising edge raises irqOut at the next rising edge.
- R7: Once irqOut has been raised, it stays high while any masked bit is pending and then drops. It does not rise again, whatever becomes pending, until end-of-interrupt is written.
- R8: Writing any value to offset 0x60 re-arms the line. irqOut then rises on the following edge if any masked bit is pending in either word, and stays low if none is.
- R9: If a hardware event pulse and a clear-port write hit the same pending bit in one cycle, the bit stays pending. Other bits in the same clear write are removed.
- R10: Writing 1 to bit 0 of offset 0x04 clears every pending and mask bit in both words, drops irqOut and re-arms the line. This takes priority over events in the same cycle. Writing 0 there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (8) | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| epTxEvt | input | EP_CNT (16) | Transmit endpoint event pulses |
| epRxEvt | input | EP_CNT-1 (15), indexed [EP_CNT-1:1] | Receive endpoint 1..15 event pulses |
| coreEvt | input | CORE_CNT (9) | Core event pulses |
| vbusDrvIn | input | 1 | Asynchronous VBUS-drive level |
| irqOut | output | 1 | Level interrupt to the processor |

## Verification
The bit mapping is exercised with event pulses at the extremes of each field (transmit 3 and 15, receive 5 and 15, core 0 and 2) and with set-port writes that touch the unimplemented bit 16. A wrong shift or an off-by-one in the receive half therefore shows up as a misplaced bit. Masking is tried with direct writes, partial set and clear patterns, and overlapping pending bits, so that the masked view distinguishes AND from OR and stale-mask behaviour. The interrupt line is taken through a full cycle: fire, clear with no acknowledge, new event while blocked, acknowledge with work left, and acknowledge with nothing left. This separates a one-shot line from a plain level OR. A same-cycle event and clear, plus a soft reset with and without bit 0 set, cover the priority rules.

// File: rtl/usb_irq_agg_pkg.sv
package usb_irq_agg_pkg;

  typedef enum logic [3:0] {
    RG_NONE, RG_REV, RG_CTRL, RG_STAT, RG_EOI,
    RG_SRC, RG_SET, RG_CLR, RG_MASK, RG_MSET, RG_MCLR, RG_MASKED
  } regId_t;

  // per-group write strobes, index 0 = endpoint word, 1 = core word
  typedef struct packed {
    logic [1:0] setWr;
    logic [1:0] clrWr;
    logic [1:0] maskWr;
    logic [1:0] mSetWr;
    logic [1:0] mClrWr;
    logic       softRst;
    logic       eoi;
  } strobe_t;

  localparam logic [7:0] OFS_REV  = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_EOI  = 8'h60;

  function automatic logic [31:0] epValidMask(int epCnt, int rxLsb);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < epCnt; i++) m[i] = 1'b1;
    for (int i = 1; i < epCnt; i++) m[rxLsb + i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] coreValidMask(int cnt, int lsb);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < cnt; i++) m[lsb + i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/usb_irq_agg_ctrl.sv
module usb_irq_agg_ctrl
  import usb_irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wBit0,
  input  logic              anyPend,
  output regId_t            regId,
  output logic              grpSel,
  output strobe_t           stb,
  output logic              armed,
  output logic              irqOut
);

  logic wrEn;
  logic [ADDR_W-6:0] blk;

  assign wrEn = busEn & busWr;
  assign blk  = busAddr[ADDR_W-1:5];

  // address decode
  always_comb begin
    regId  = RG_NONE;
    grpSel = 1'b0;
    if (busAddr == ADDR_W'(OFS_REV))       regId = RG_REV;
    else if (busAddr == ADDR_W'(OFS_CTRL)) regId = RG_CTRL;
    else if (busAddr == ADDR_W'(OFS_STAT)) regId = RG_STAT;
    else if (busAddr == ADDR_W'(OFS_EOI))  regId = RG_EOI;
    else if (blk == (ADDR_W-5)'(1) || blk == (ADDR_W-5)'(2)) begin
      grpSel = (blk == (ADDR_W-5)'(2));
      case (busAddr[4:0])
        5'h00:   regId = RG_SRC;
        5'h04:   regId = RG_SET;
        5'h08:   regId = RG_CLR;
        5'h0C:   regId = RG_MASK;
        5'h10:   regId = RG_MSET;
        5'h14:   regId = RG_MCLR;
        5'h18:   regId = RG_MASKED;
        default: regId = RG_NONE;
      endcase
    end
  end

  // strobes towards the datapath
  always_comb begin
    stb = '0;
    for (int g = 0; g < 2; g++) begin
      stb.setWr[g]  = wrEn && regId == RG_SET  && int'(grpSel) == g;
      stb.clrWr[g]  = wrEn && regId == RG_CLR  && int'(grpSel) == g;
      stb.maskWr[g] = wrEn && regId == RG_MASK && int'(grpSel) == g;
      stb.mSetWr[g] = wrEn && regId == RG_MSET && int'(grpSel) == g;
      stb.mClrWr[g] = wrEn && regId == RG_MCLR && int'(grpSel) == g;
    end
    stb.softRst = wrEn && regId == RG_CTRL && wBit0;
    stb.eoi     = wrEn && regId == RG_EOI;
  end

  // one-shot interrupt line, re-armed by end-of-interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b1;
      irqOut <= 1'b0;
    end else if (stb.softRst) begin
      armed  <= 1'b1;
      irqOut <= 1'b0;
    end else begin
      if (stb.eoi)               armed <= 1'b1;
      else if (armed && anyPend) armed <= 1'b0;
      irqOut <= irqOut ? anyPend : (armed && anyPend);
    end
  end

endmodule

// File: rtl/usb_irq_agg_dp.sv
module usb_irq_agg_dp
  import usb_irq_agg_pkg::*;
#(
  parameter int          EP_CNT   = 16,
  parameter int          RX_LSB   = 16,
  parameter int          CORE_CNT = 9,
  parameter int          CORE_LSB = 16,
  parameter logic [31:0] REV_ID   = 32'h0002_0C31
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  regId_t                  regId,
  input  logic                    grpSel,
  input  logic [31:0]             busWdata,
  input  logic [EP_CNT-1:0]       epTxEvt,
  input  logic [EP_CNT-1:1]       epRxEvt,
  input  logic [CORE_CNT-1:0]     coreEvt,
  input  logic                    vbusDrvIn,
  output logic [1:0][31:0]        srcOut,
  output logic [1:0][31:0]        maskOut,
  output logic                    anyPend,
  output logic [31:0]             busRdata
);

  localparam logic [31:0] EP_VALID   = epValidMask(EP_CNT, RX_LSB);
  localparam logic [31:0] CORE_VALID = coreValidMask(CORE_CNT, CORE_LSB);
  localparam logic [1:0][31:0] VALID = {CORE_VALID, EP_VALID};

  logic [1:0][31:0] hwEvt;
  logic [1:0][31:0] srcQ;
  logic [1:0][31:0] maskQ;
  logic [1:0]       vbusSync;

  // place event pulses into their word positions
  always_comb begin
    hwEvt = '0;
    for (int i = 0; i < EP_CNT; i++)   hwEvt[0][i] = epTxEvt[i];
    for (int i = 1; i < EP_CNT; i++)   hwEvt[0][RX_LSB + i] = epRxEvt[i];
    for (int i = 0; i < CORE_CNT; i++) hwEvt[1][CORE_LSB + i] = coreEvt[i];
  end

  for (genvar g = 0; g < 2; g++) begin : gGrp
    logic [31:0] setBits, clrBits, mSetBits, mClrBits;
    assign setBits  = stb.setWr[g]  ? busWdata : '0;
    assign clrBits  = stb.clrWr[g]  ? busWdata : '0;
    assign mSetBits = stb.mSetWr[g] ? busWdata : '0;
    assign mClrBits = stb.mClrWr[g] ? busWdata : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcQ[g]  <= '0;
        maskQ[g] <= '0;
      end else if (stb.softRst) begin
        srcQ[g]  <= '0;
        maskQ[g] <= '0;
      end else begin
        // hardware event is ORed after the clear, so it wins a collision
        srcQ[g] <= ((srcQ[g] & ~clrBits) | setBits | hwEvt[g]) & VALID[g];
        if (stb.maskWr[g]) maskQ[g] <= busWdata & VALID[g];
        else               maskQ[g] <= ((maskQ[g] | mSetBits) & ~mClrBits) & VALID[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vbusSync <= '0;
    else       vbusSync <= {vbusSync[0], vbusDrvIn};
  end

  assign srcOut  = srcQ;
  assign maskOut = maskQ;
  assign anyPend = |(srcQ[0] & maskQ[0]) | |(srcQ[1] & maskQ[1]);

  always_comb begin
    case (regId)
      RG_REV:    busRdata = REV_ID;
      RG_STAT:   busRdata = {31'b0, vbusSync[1]};
      RG_SRC:    busRdata = srcQ[grpSel];
      RG_MASK:   busRdata = maskQ[grpSel];
      RG_MASKED: busRdata = srcQ[grpSel] & maskQ[grpSel];
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
  import usb_irq_agg_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          EP_CNT   = 16,
  parameter int          RX_LSB   = 16,
  parameter int          CORE_CNT = 9,
  parameter int          CORE_LSB = 16,
  parameter logic [31:0] REV_ID   = 32'h0002_0C31
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busEn,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [EP_CNT-1:0]   epTxEvt,
  input  logic [EP_CNT-1:1]   epRxEvt,
  input  logic [CORE_CNT-1:0] coreEvt,
  input  logic                vbusDrvIn,
  output logic                irqOut
);

  localparam logic [31:0] CORE_VALID = coreValidMask(CORE_CNT, CORE_LSB);

  regId_t           regId;
  logic             grpSel;
  strobe_t          stb;
  logic             armed;
  logic             anyPend;
  logic [1:0][31:0] srcOut;
  logic [1:0][31:0] maskOut;
  logic [31:0]      epSrc, coreSrc, epMask, coreMask, coreValid;

  assign epSrc     = srcOut[0];
  assign coreSrc   = srcOut[1];
  assign epMask    = maskOut[0];
  assign coreMask  = maskOut[1];
  assign coreValid = CORE_VALID;

  usb_irq_agg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr),
    .busAddr(busAddr), .wBit0(busWdata[0]), .anyPend(anyPend),
    .regId(regId), .grpSel(grpSel), .stb(stb), .armed(armed),
    .irqOut(irqOut)
  );

  usb_irq_agg_dp #(
    .EP_CNT(EP_CNT), .RX_LSB(RX_LSB), .CORE_CNT(CORE_CNT),
    .CORE_LSB(CORE_LSB), .REV_ID(REV_ID)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .regId(regId), .grpSel(grpSel),
    .busWdata(busWdata), .epTxEvt(epTxEvt), .epRxEvt(epRxEvt),
    .coreEvt(coreEvt), .vbusDrvIn(vbusDrvIn), .srcOut(srcOut),
    .maskOut(maskOut), .anyPend(anyPend), .busRdata(busRdata)
  );

endmodule

// File: rtl/usb_irq_agg_chk.sv
module usb_irq_agg_chk
  import usb_irq_agg_pkg::*;
#(
  parameter int RX_LSB = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        irqOut,
  input logic        anyPend,
  input logic        armed,
  input strobe_t     stb,
  input logic        epTx0,
  input logic [31:0] epSrc,
  input logic [31:0] coreSrc,
  input logic [31:0] epMask,
  input logic [31:0] coreMask,
  input logic [31:0] coreValid
);

  p_rx0_absent_r2: assert property (@(posedge clk) disable iff (!rstN)
    !epSrc[RX_LSB]);

  p_core_field_r3: assert property (@(posedge clk) disable iff (!rstN)
    (coreSrc & ~coreValid) == 32'h0);

  p_fire_when_armed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && anyPend && !stb.softRst) |=> irqOut);

  p_line_has_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(anyPend));

  p_blocked_until_eoi_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !armed && !stb.eoi) |=> !irqOut);

  p_eoi_rearms_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.eoi |=> armed);

  p_event_beats_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (epTx0 && !stb.softRst) |=> epSrc[0]);

  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (epSrc == 32'h0 && coreSrc == 32'h0 &&
                     epMask == 32'h0 && coreMask == 32'h0 && !irqOut));

endmodule

bind usb_irq_agg usb_irq_agg_chk #(.RX_LSB(RX_LSB)) chk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .anyPend(anyPend),
  .armed(armed), .stb(stb), .epTx0(epTxEvt[0]), .epSrc(epSrc),
  .coreSrc(coreSrc), .epMask(epMask), .coreMask(coreMask),
  .coreValid(coreValid)
);

// File: tb/usb_irq_agg_test.sv
module usb_irq_agg_test;

  localparam logic [7:0] A_REV = 8'h00, A_CTRL = 8'h04, A_STAT = 8'h08, A_EOI = 8'h60;
  localparam logic [7:0] EP = 8'h20, CO = 8'h40;
  localparam logic [7:0] O_SRC = 8'h00, O_SET = 8'h04, O_CLR = 8'h08, O_MASK = 8'h0C;
  localparam logic [7:0] O_MSET = 8'h10, O_MCLR = 8'h14, O_MSKD = 8'h18;
  localparam logic [31:0] REV = 32'h0002_0C31;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] epTxEvt = '0;
  logic [15:1] epRxEvt = '0;
  logic [8:0]  coreEvt = '0;
  logic        vbusDrvIn = 1'b0;
  logic        irqOut;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usb_irq_agg uut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .epTxEvt(epTxEvt),
    .epRxEvt(epRxEvt), .coreEvt(coreEvt), .vbusDrvIn(vbusDrvIn), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a; busEn = 1'b1; busWr = 1'b0;
    #1;
    check(tag, busRdata, exp);
    busEn = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] tx, input logic [15:1] rx, input logic [8:0] co);
    @(negedge clk);
    epTxEvt = tx; epRxEvt = rx; coreEvt = co;
    @(negedge clk);
    epTxEvt = '0; epRxEvt = '0; coreEvt = '0;
  endtask

  task automatic tReset;
    check("R6 reset irqOut low", {31'b0, irqOut}, 32'h0);
    rdChk("R2 reset ep src", EP + O_SRC, 32'h0);
    rdChk("R5 reset core mask", CO + O_MASK, 32'h0);
  endtask

  task automatic tGlobalR1;
    rdChk("R1 revision", A_REV, REV);
    rdChk("R1 control reads 0", A_CTRL, 32'h0);
    rdChk("R1 unmapped reads 0", 8'h5C, 32'h0);
    @(negedge clk); vbusDrvIn = 1'b1;
    idle(1);
    rdChk("R1 status after one edge", A_STAT, 32'h0);
    idle(1);
    rdChk("R1 status after two edges", A_STAT, 32'h1);
  endtask

  task automatic tEndpointR2;
    logic [15:1] rx = '0;
    rx[5] = 1'b1; rx[15] = 1'b1;
    pulse(16'h8008, rx, 9'h0);
    rdChk("R2 ep mapping", EP + O_SRC, 32'h8020_8008);
    wr(EP + O_CLR, 32'hFFFF_FFFF);
    wr(EP + O_SET, 32'h0001_0000);
    rdChk("R2 bit16 stays zero", EP + O_SRC, 32'h0);
  endtask

  task automatic tCoreR3;
    pulse(16'h0, 15'h0, 9'h005);
    rdChk("R3 core mapping", CO + O_SRC, 32'h0005_0000);
    wr(CO + O_SET, 32'hFFFF_FFFF);
    rdChk("R3 core set fills field only", CO + O_SRC, 32'h01FF_0000);
    wr(CO + O_CLR, 32'hFFFF_FFFF);
    wr(CO + O_SET, 32'h0100_0000);
    rdChk("R3 forced vbus-drive event", CO + O_SRC, 32'h0100_0000);
    wr(CO + O_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic tWriteOneR4;
    wr(EP + O_SET, 32'h5);
    wr(EP + O_CLR, 32'h4);
    rdChk("R4 clear removes one bit", EP + O_SRC, 32'h1);
    wr(EP + O_CLR, 32'h0);
    rdChk("R4 zero clear no effect", EP + O_SRC, 32'h1);
    wr(EP + O_SET, 32'h0);
    rdChk("R4 zero set no effect", EP + O_SRC, 32'h1);
    wr(EP + O_SRC, 32'hFFFF);
    rdChk("R4 raw write ignored", EP + O_SRC, 32'h1);
    rdChk("R4 set reads 0", EP + O_SET, 32'h0);
    rdChk("R4 clear reads 0", CO + O_CLR, 32'h0);
    rdChk("R4 mask-set reads 0", EP + O_MSET, 32'h0);
    rdChk("R4 mask-clear reads 0", CO + O_MCLR, 32'h0);
    wr(EP + O_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic tMaskR5;
    wr(EP + O_MASK, 32'hFFFF_FFFF);
    rdChk("R5 mask valid bits", EP + O_MASK, 32'hFFFE_FFFF);
    wr(EP + O_MCLR, 32'hFFFF_FFFF);
    rdChk("R5 mask-clear all", EP + O_MASK, 32'h0);
    wr(EP + O_MASK, 32'h00FF_00FF);
    wr(EP + O_MSET, 32'h0000_0100);
    wr(EP + O_MCLR, 32'h0000_0001);
    rdChk("R5 mask set/clear", EP + O_MASK, 32'h00FE_01FE);
    wr(EP + O_SET, 32'h0003_0003);
    rdChk("R5 masked view", EP + O_MSKD, 32'h0002_0002);
    wr(CO + O_MSET, 32'h0100_0000);
    rdChk("R5 core mask-set", CO + O_MASK, 32'h0100_0000);
  endtask

  task automatic tIrqR6toR8;
    wr(A_CTRL, 32'h1);
    wr(CO + O_MASK, 32'h0100_0000);
    wr(CO + O_SET, 32'h0100_0000);
    check("R6 not yet raised", {31'b0, irqOut}, 32'h0);
    idle(1);
    check("R6 raised next edge", {31'b0, irqOut}, 32'h1);
    rdChk("R6 core masked view", CO + O_MSKD, 32'h0100_0000);
    wr(CO + O_CLR, 32'h0100_0000);
    idle(1);
    check("R7 drops after clear", {31'b0, irqOut}, 32'h0);
    pulse(16'h0, 15'h0, 9'h100);
    idle(3);
    check("R7 blocked without eoi", {31'b0, irqOut}, 32'h0);
    wr(A_EOI, 32'h1234);
    idle(1);
    check("R8 reasserts after eoi", {31'b0, irqOut}, 32'h1);
    wr(CO + O_CLR, 32'hFFFF_FFFF);
    wr(A_EOI, 32'h0);
    idle(2);
    check("R8 stays low with nothing pending", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic tRaceR9;
    wr(EP + O_SET, 32'h30);
    @(negedge clk);
    epTxEvt = 16'h0010;
    busEn = 1'b1; busWr = 1'b1; busAddr = EP + O_CLR; busWdata = 32'h30;
    @(negedge clk);
    epTxEvt = '0; busEn = 1'b0; busWr = 1'b0;
    rdChk("R9 event beats clear", EP + O_SRC, 32'h10);
    wr(EP + O_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic tSoftResetR10;
    wr(EP + O_MASK, 32'hF);
    wr(EP + O_SET, 32'hF);
    wr(A_CTRL, 32'h0);
    rdChk("R10 ctrl zero keeps src", EP + O_SRC, 32'hF);
    rdChk("R10 ctrl zero keeps mask", EP + O_MASK, 32'hF);
    wr(A_CTRL, 32'h1);
    rdChk("R10 src cleared", EP + O_SRC, 32'h0);
    rdChk("R10 mask cleared", EP + O_MASK, 32'h0);
    rdChk("R10 core mask cleared", CO + O_MASK, 32'h0);
    check("R10 line dropped", {31'b0, irqOut}, 32'h0);
    wr(EP + O_MASK, 32'h1);
    wr(EP + O_SET, 32'h1);
    idle(1);
    check("R10 line re-armed", {31'b0, irqOut}, 32'h1);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    tReset();
    tGlobalR1();
    tEndpointR2();
    tCoreR3();
    tWriteOneR4();
    tMaskR5();
    tIrqR6toR8();
    tRaceR9();
    tSoftResetR10();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule